// File: doc/BRIEF.md
# Single-Cycle Word-Addressed Integer Core

This block is a small 32-bit processor core that completes one instruction on every rising clock edge. Fetch, decode, operand read, arithmetic, memory access and register write-back all resolve combinationally inside one cycle. The next clock edge then commits the new program counter, any register write and any data-memory store. The core has no pipeline, so it has no hazards, stalls or forwarding.

Program and data sit in two separate word-addressed memories. The program memory is filled through a dedicated write port while reset is held. After reset is released, the core runs from word 0. The instruction set covers three-register arithmetic and logic, immediate forms of the same operations, word load and store, branch-if-equal, absolute jump and jump through a register. Multiply, divide and remainder are ordinary single-cycle operations. A zero divisor yields a zero result and does not stall the core. Four observation outputs show the current program counter and the register write about to retire, so a testbench can follow execution cycle by cycle.

Top module: `scc_core`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0 and `rf_we_o` is 0. After release, every instruction that is not a taken branch or a jump advances `pc_o` by exactly 1.
- R2: An instruction with bits [31:26]=0 is register-register. It reads registers rs=[25:21] and rt=[20:16] and writes rd=[15:11]. Bits [5:0] select the operation: 0x20 add, 0x22 sub, 0x18 multiply (low 32 bits), 0x1A divide, 0x1B remainder, 0x24 and, 0x25 or, 0x2A set-less-than.
- R3: Set-less-than compares as signed two's complement and writes 1 or 0. Divide truncates toward zero. Remainder takes the sign of the dividend.
- R4: The immediate forms use opcode 0x08 add, 0x09 sub, 0x1C multiply, 0x1D divide, 0x1E remainder, 0x0C and, 0x0D or, 0x0A set-less-than. Each combines rs with the sign-extended 16-bit field [15:0] and writes the result to rt.
- R5: A divide or remainder whose divisor is zero, whether from a register or an immediate, writes 0 to its destination. The following instruction still executes in the next cycle.
- R6: Register 0 reads as zero. An instruction targeting register 0 produces no write (`rf_we_o` stays 0).
- R7: Load (opcode 0x23) writes to rt the data word at address rs + sext(imm). Store (opcode 0x2B) writes rt to that address and produces no register write.
- R8: Branch (opcode 0x04) compares rs and rt. If they are equal, the next PC is PC + 1 + sext(imm), where the offset may be negative. Otherwise the next PC is PC + 1. The branch writes no register.
- R9: Jump (opcode 0x02) loads the zero-extended 26-bit field [25:0] into the PC.
- R10: Jump-register (opcode 0, bits [5:0]=0x08) loads the PC from register rs and writes no register.
- R11: While reset is held, a word presented with `imem_we` high is written into program memory at `imem_waddr` on the clock edge, and it later executes at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_we | input | 1 | Program memory write strobe |
| imem_waddr | input | 6 | Program memory word address (log2 of IMEM_DEPTH) |
| imem_wdata | input | 32 | Program word to write |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_we_o | output | 1 | Register write retires at the next edge |
| rf_waddr_o | output | 5 | Destination register index |
| rf_wdata_o | output | 32 | Value written to the destination |

## Verification
The bench builds the core with its default parameters: a 32-bit data path and two 64-word memories. This depth is enough for a program that jumps forward to word 20 and branches backwards from there, and for data accesses at addresses formed with positive and negative offsets. With the full 32-bit width, sign-extended negative immediates, signed division and remainder of mixed-sign operands, and the all-ones result of a logical OR can all be observed directly on the write-back outputs.

// File: rtl/scc_pkg.sv
package scc_pkg;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV,
        ALU_MOD, ALU_AND, ALU_OR,  ALU_SLT
    } alu_op_e;

    // primary opcodes, bits [31:26]
    localparam logic [5:0] OP_REG  = 6'h00;
    localparam logic [5:0] OP_J    = 6'h02;
    localparam logic [5:0] OP_BEQ  = 6'h04;
    localparam logic [5:0] OP_ADDI = 6'h08;
    localparam logic [5:0] OP_SUBI = 6'h09;
    localparam logic [5:0] OP_SLTI = 6'h0A;
    localparam logic [5:0] OP_ANDI = 6'h0C;
    localparam logic [5:0] OP_ORI  = 6'h0D;
    localparam logic [5:0] OP_MULI = 6'h1C;
    localparam logic [5:0] OP_DIVI = 6'h1D;
    localparam logic [5:0] OP_MODI = 6'h1E;
    localparam logic [5:0] OP_LW   = 6'h23;
    localparam logic [5:0] OP_SW   = 6'h2B;

    // function codes, bits [5:0] of register-register words
    localparam logic [5:0] FN_JR  = 6'h08;
    localparam logic [5:0] FN_MUL = 6'h18;
    localparam logic [5:0] FN_DIV = 6'h1A;
    localparam logic [5:0] FN_MOD = 6'h1B;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef struct packed {
        alu_op_e alu_op;
        logic    use_imm;
        logic    wr_reg;
        logic    dst_rd;
        logic    load;
        logic    store;
        logic    branch;
        logic    jump;
        logic    jump_reg;
    } ctrl_t;

endpackage

// File: rtl/scc_decode.sv
module scc_decode
    import scc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_ADD;
        ctrl.use_imm = 1'b1;
        unique case (opcode)
            OP_REG: begin
                ctrl.use_imm = 1'b0;
                ctrl.dst_rd  = 1'b1;
                ctrl.wr_reg  = 1'b1;
                unique case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_MUL:  ctrl.alu_op = ALU_MUL;
                    FN_DIV:  ctrl.alu_op = ALU_DIV;
                    FN_MOD:  ctrl.alu_op = ALU_MOD;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    FN_JR: begin
                        ctrl.wr_reg   = 1'b0;
                        ctrl.jump_reg = 1'b1;
                    end
                    default: ctrl.wr_reg = 1'b0;
                endcase
            end
            OP_ADDI: begin ctrl.wr_reg = 1'b1; ctrl.alu_op = ALU_ADD; end
            OP_SUBI: begin ctrl.wr_reg = 1'b1; ctrl.alu_op = ALU_SUB; end
            OP_MULI: begin ctrl.wr_reg = 1'b1; ctrl.alu_op = ALU_MUL; end
            OP_DIVI: begin ctrl.wr_reg = 1'b1; ctrl.alu_op = ALU_DIV; end
            OP_MODI: begin ctrl.wr_reg = 1'b1; ctrl.alu_op = ALU_MOD; end
            OP_ANDI: begin ctrl.wr_reg = 1'b1; ctrl.alu_op = ALU_AND; end
            OP_ORI:  begin ctrl.wr_reg = 1'b1; ctrl.alu_op = ALU_OR;  end
            OP_SLTI: begin ctrl.wr_reg = 1'b1; ctrl.alu_op = ALU_SLT; end
            OP_LW:   begin ctrl.wr_reg = 1'b1; ctrl.load = 1'b1; end
            OP_SW:   ctrl.store  = 1'b1;
            OP_BEQ:  ctrl.branch = 1'b1;
            OP_J:    ctrl.jump   = 1'b1;
            default: ctrl.use_imm = 1'b0;
        endcase
    end

endmodule

// File: rtl/scc_alu.sv
module scc_alu
    import scc_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  alu_op_e          op,
    input  logic [XLEN-1:0]  a,
    input  logic [XLEN-1:0]  b,
    output logic [XLEN-1:0]  y
);

    logic signed [XLEN-1:0] sa, sb;
    logic                   b_zero;

    assign sa     = $signed(a);
    assign sb     = $signed(b);
    assign b_zero = (b == '0);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_MUL: y = a * b;
            ALU_DIV: y = b_zero ? '0 : XLEN'(sa / sb);
            ALU_MOD: y = b_zero ? '0 : XLEN'(sa % sb);
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = (sa < sb) ? XLEN'(1) : '0;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/scc_regfile.sv
module scc_regfile #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned NREG = 32,
    localparam int unsigned AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra_addr,
    input  logic [AW-1:0]   rb_addr,
    output logic [XLEN-1:0] ra_data,
    output logic [XLEN-1:0] rb_data,
    input  logic            w_en,
    input  logic [AW-1:0]   w_addr,
    input  logic [XLEN-1:0] w_data
);

    logic [NREG-1:0][XLEN-1:0] regs;

    assign regs[0] = '0;

    for (genvar g = 1; g < NREG; g++) begin : g_reg
        logic [XLEN-1:0] word_d, word_q;
        always_comb begin
            word_d = word_q;
            if (w_en && (w_addr == AW'(g))) word_d = w_data;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end
        assign regs[g] = word_q;
    end

    assign ra_data = regs[ra_addr];
    assign rb_data = regs[rb_addr];

endmodule

// File: rtl/scc_core.sv
module scc_core
    import scc_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned IMEM_DEPTH = 64,
    parameter int unsigned DMEM_DEPTH = 64,
    localparam int unsigned IA_W      = $clog2(IMEM_DEPTH),
    localparam int unsigned DA_W      = $clog2(DMEM_DEPTH),
    localparam int unsigned RA_W      = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            imem_we,
    input  logic [IA_W-1:0] imem_waddr,
    input  logic [31:0]     imem_wdata,
    output logic [XLEN-1:0] pc_o,
    output logic            rf_we_o,
    output logic [RA_W-1:0] rf_waddr_o,
    output logic [XLEN-1:0] rf_wdata_o
);

    localparam logic [XLEN-1:0] ONE = XLEN'(1);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } state_t;

    state_t state_d, state_q;

    logic [31:0]     imem_q [IMEM_DEPTH];
    logic [XLEN-1:0] dmem_q [DMEM_DEPTH];

    logic [31:0]     instr;
    ctrl_t           ctrl;
    logic [XLEN-1:0] rs_val, rt_val, imm_x, alu_b, alu_y, ld_val;
    logic [RA_W-1:0] dst;
    logic [DA_W-1:0] d_addr;

    assign instr = imem_q[state_q.pc[IA_W-1:0]];
    assign imm_x = {{(XLEN-16){instr[15]}}, instr[15:0]};

    scc_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    scc_regfile #(.XLEN(XLEN), .NREG(1 << RA_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (instr[25:21]),
        .rb_addr (instr[20:16]),
        .ra_data (rs_val),
        .rb_data (rt_val),
        .w_en    (rf_we_o),
        .w_addr  (rf_waddr_o),
        .w_data  (rf_wdata_o)
    );

    assign alu_b = ctrl.use_imm ? imm_x : rt_val;

    scc_alu #(.XLEN(XLEN)) u_alu (
        .op (ctrl.alu_op),
        .a  (rs_val),
        .b  (alu_b),
        .y  (alu_y)
    );

    assign d_addr = alu_y[DA_W-1:0];
    assign ld_val = dmem_q[d_addr];
    assign dst    = ctrl.dst_rd ? instr[15:11] : instr[20:16];

    // retirement view
    assign rf_we_o    = rst_n && ctrl.wr_reg && (dst != '0);
    assign rf_waddr_o = dst;
    assign rf_wdata_o = ctrl.load ? ld_val : alu_y;
    assign pc_o       = state_q.pc;

    // next-state computation
    always_comb begin
        state_d.pc = state_q.pc + ONE;
        if (ctrl.jump_reg)
            state_d.pc = rs_val;
        else if (ctrl.jump)
            state_d.pc = XLEN'(instr[25:0]);
        else if (ctrl.branch && (rs_val == rt_val))
            state_d.pc = state_q.pc + ONE + imm_x;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n && imem_we) imem_q[imem_waddr] <= imem_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst_n && ctrl.store) dmem_q[d_addr] <= rt_val;
    end

endmodule

// File: rtl/scc_core_chk.sv
module scc_core_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc_o,
    input logic [31:0]     instr,
    input logic [XLEN-1:0] rs_val,
    input logic [XLEN-1:0] rt_val,
    input logic            rf_we_o,
    input logic [4:0]      rf_waddr_o,
    input logic [XLEN-1:0] rf_wdata_o
);

    logic is_reg, is_jr, is_j, is_beq, flow;
    logic div0_reg, div0_imm;

    assign is_reg   = (instr[31:26] == 6'h00);
    assign is_jr    = is_reg && (instr[5:0] == 6'h08);
    assign is_j     = (instr[31:26] == 6'h02);
    assign is_beq   = (instr[31:26] == 6'h04);
    assign flow     = is_jr || is_j || (is_beq && (rs_val == rt_val));
    assign div0_reg = is_reg && ((instr[5:0] == 6'h1A) || (instr[5:0] == 6'h1B)) && (rt_val == '0);
    assign div0_imm = ((instr[31:26] == 6'h1D) || (instr[31:26] == 6'h1E)) && (instr[15:0] == 16'h0);

    AST_RESET_PC: assert property (@(posedge clk) !rst_n |=> pc_o == '0); // R1
    AST_RESET_NO_WRITE: assert property (@(posedge clk) !rst_n |-> !rf_we_o); // R1
    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        !flow |=> pc_o == $past(pc_o) + XLEN'(1)); // R1
    AST_ZERO_REG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> rf_waddr_o != 5'd0); // R6
    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we_o && (div0_reg || div0_imm)) |-> rf_wdata_o == '0); // R5
    AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (is_beq && rs_val == rt_val) |=>
        pc_o == $past(pc_o) + XLEN'(1) + {{(XLEN-16){$past(instr[15])}}, $past(instr[15:0])}); // R8
    AST_J_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        is_j |=> pc_o == XLEN'($past(instr[25:0]))); // R9
    AST_JR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        is_jr |=> pc_o == $past(rs_val)); // R10
    AST_FLOW_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_jr || is_j || is_beq) |-> !rf_we_o); // R8

endmodule

bind scc_core scc_core_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_o       (pc_o),
    .instr      (instr),
    .rs_val     (rs_val),
    .rt_val     (rt_val),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .rf_wdata_o (rf_wdata_o)
);

// File: tb/scc_core_bench.sv
module scc_core_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_waddr = '0;
    logic [31:0] imem_wdata = '0;
    logic [31:0] pc_o;
    logic        rf_we_o;
    logic [4:0]  rf_waddr_o;
    logic [31:0] rf_wdata_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] prog [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    scc_core u_scc_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_we    (imem_we),
        .imem_waddr (imem_waddr),
        .imem_wdata (imem_wdata),
        .pc_o       (pc_o),
        .rf_we_o    (rf_we_o),
        .rf_waddr_o (rf_waddr_o),
        .rf_wdata_o (rf_wdata_o)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        logic [31:0] v = imm;
        return {op, 5'(rs), 5'(rt), v[15:0]};
    endfunction

    function automatic logic [31:0] enc_j(int target);
        logic [31:0] v = target;
        return {6'h02, v[25:0]};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // checks the instruction executing now, then advances one cycle
    task automatic step(string req, int exp_pc, bit exp_we, int exp_wa, logic [31:0] exp_wd);
        check(req, "pc", pc_o, 32'(exp_pc));
        check(req, "write enable", 32'(rf_we_o), 32'(exp_we));
        if (exp_we) begin
            check(req, "write addr", 32'(rf_waddr_o), 32'(exp_wa));
            check(req, "write data", rf_wdata_o, exp_wd);
        end
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    // R11: program is written while reset is held, then reset is released
    task automatic load_and_start(int n);
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            imem_we    = 1'b1;
            imem_waddr = 6'(i);
            imem_wdata = prog[i];
            @(negedge clk);
        end
        imem_we = 1'b0;
        rst_n   = 1'b1;
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "pc in reset", pc_o, 32'h0);
        check("R1", "no write in reset", 32'(rf_we_o), 32'h0);
    endtask

    task automatic t_reg_ops;
        prog[0]  = enc_i(6'h08, 0, 1, 7);
        prog[1]  = enc_i(6'h08, 0, 2, -3);
        prog[2]  = enc_r(1, 2, 3, 6'h20);
        prog[3]  = enc_r(1, 2, 4, 6'h22);
        prog[4]  = enc_r(1, 2, 5, 6'h18);
        prog[5]  = enc_r(1, 2, 6, 6'h1A);
        prog[6]  = enc_r(1, 2, 7, 6'h1B);
        prog[7]  = enc_r(1, 2, 8, 6'h24);
        prog[8]  = enc_r(1, 2, 9, 6'h25);
        prog[9]  = enc_r(2, 1, 10, 6'h2A);
        prog[10] = enc_r(1, 2, 11, 6'h2A);
        load_and_start(11);
        step("R11", 0, 1, 1, 32'd7);
        step("R4", 1, 1, 2, 32'hFFFF_FFFD);
        step("R2", 2, 1, 3, 32'd4);
        step("R2", 3, 1, 4, 32'd10);
        step("R2", 4, 1, 5, 32'hFFFF_FFEB);
        step("R3", 5, 1, 6, 32'hFFFF_FFFE);
        step("R3", 6, 1, 7, 32'd1);
        step("R2", 7, 1, 8, 32'd5);
        step("R2", 8, 1, 9, 32'hFFFF_FFFF);
        step("R3", 9, 1, 10, 32'd1);
        step("R3", 10, 1, 11, 32'd0);
        check("R1", "sequential pc", pc_o, 32'd11);
    endtask

    task automatic t_imm_ops;
        prog[0] = enc_i(6'h08, 0, 1, 7);
        prog[1] = enc_i(6'h09, 1, 2, 2);
        prog[2] = enc_i(6'h1C, 1, 3, -2);
        prog[3] = enc_i(6'h1D, 1, 4, 2);
        prog[4] = enc_i(6'h1E, 1, 5, 4);
        prog[5] = enc_i(6'h0C, 1, 6, 5);
        prog[6] = enc_i(6'h0D, 1, 7, 8);
        prog[7] = enc_i(6'h0A, 1, 8, 8);
        prog[8] = enc_i(6'h0A, 1, 9, -1);
        load_and_start(9);
        step("R4", 0, 1, 1, 32'd7);
        step("R4", 1, 1, 2, 32'd5);
        step("R4", 2, 1, 3, 32'hFFFF_FFF2);
        step("R4", 3, 1, 4, 32'd3);
        step("R4", 4, 1, 5, 32'd3);
        step("R4", 5, 1, 6, 32'd5);
        step("R4", 6, 1, 7, 32'd15);
        step("R4", 7, 1, 8, 32'd1);
        step("R4", 8, 1, 9, 32'd0);
    endtask

    task automatic t_div_zero;
        prog[0] = enc_i(6'h08, 0, 1, 9);
        prog[1] = enc_r(1, 0, 2, 6'h1A);
        prog[2] = enc_r(1, 0, 3, 6'h1B);
        prog[3] = enc_i(6'h1D, 1, 4, 0);
        prog[4] = enc_i(6'h1E, 1, 5, 0);
        prog[5] = enc_i(6'h08, 0, 6, 1);
        load_and_start(6);
        step("R5", 0, 1, 1, 32'd9);
        step("R5", 1, 1, 2, 32'd0);
        step("R5", 2, 1, 3, 32'd0);
        step("R5", 3, 1, 4, 32'd0);
        step("R5", 4, 1, 5, 32'd0);
        step("R5", 5, 1, 6, 32'd1);
    endtask

    task automatic t_zero_reg;
        prog[0] = enc_i(6'h08, 0, 0, 5);
        prog[1] = enc_r(0, 0, 1, 6'h20);
        prog[2] = enc_i(6'h08, 0, 2, 3);
        prog[3] = enc_r(0, 2, 3, 6'h20);
        load_and_start(4);
        step("R6", 0, 0, 0, 32'd0);
        step("R6", 1, 1, 1, 32'd0);
        step("R6", 2, 1, 2, 32'd3);
        step("R6", 3, 1, 3, 32'd3);
    endtask

    task automatic t_memory;
        prog[0] = enc_i(6'h08, 0, 1, 10);
        prog[1] = enc_i(6'h08, 0, 2, 32'h55);
        prog[2] = enc_i(6'h2B, 1, 2, 3);
        prog[3] = enc_i(6'h23, 1, 3, 3);
        prog[4] = enc_i(6'h2B, 1, 1, -1);
        prog[5] = enc_i(6'h23, 0, 4, 9);
        load_and_start(6);
        step("R7", 0, 1, 1, 32'd10);
        step("R7", 1, 1, 2, 32'h55);
        step("R7", 2, 0, 0, 32'd0);
        step("R7", 3, 1, 3, 32'h55);
        step("R7", 4, 0, 0, 32'd0);
        step("R7", 5, 1, 4, 32'd10);
    endtask

    task automatic t_flow;
        for (int i = 0; i < 32; i++) prog[i] = enc_i(6'h08, 0, 31, 32'hBAD);
        prog[0]  = enc_i(6'h08, 0, 1, 4);
        prog[1]  = enc_i(6'h04, 1, 0, 5);
        prog[2]  = enc_i(6'h08, 0, 2, 4);
        prog[3]  = enc_i(6'h04, 1, 2, 2);
        prog[6]  = enc_j(9);
        prog[9]  = enc_i(6'h08, 0, 3, 12);
        prog[10] = enc_r(3, 0, 0, 6'h08);
        prog[12] = enc_i(6'h08, 0, 4, 1);
        prog[13] = enc_j(20);
        prog[20] = enc_i(6'h04, 0, 0, -6);
        prog[15] = enc_i(6'h08, 0, 5, 3);
        load_and_start(32);
        step("R8", 0, 1, 1, 32'd4);
        step("R8", 1, 0, 0, 32'd0);
        step("R8", 2, 1, 2, 32'd4);
        step("R8", 3, 0, 0, 32'd0);
        step("R9", 6, 0, 0, 32'd0);
        step("R9", 9, 1, 3, 32'd12);
        step("R10", 10, 0, 0, 32'd0);
        step("R10", 12, 1, 4, 32'd1);
        step("R9", 13, 0, 0, 32'd0);
        step("R8", 20, 0, 0, 32'd0);
        step("R8", 15, 1, 5, 32'd3);
    endtask

    initial begin
        t_reset();
        t_reg_ops();
        t_imm_ops();
        t_div_zero();
        t_zero_reg();
        t_memory();
        t_flow();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule